// File: doc/BRIEF.md
# Timed and Pin-Change Wake Sequencer

This block runs the sleep cycle of a battery-powered radio node. While asleep it watches two things: a long-period timer counted in coarse units, and a group of eight input pins selected by a mask. When either one fires, the node wakes. It then asks the radio to send one broadcast check-in message, whose command code says which source woke it. After that it waits a programmed number of half-second units for a reply.

If no reply comes, the check-in goes out once more. If that second message also goes unanswered, the node goes back to sleep. A reply ends the retries, and the node then stays awake for one more window of the same length. A sleep-now strobe from the host ends any awake phase at once. Low-power sequencing is chosen by a mode pin that is sampled only while reset is held. If that pin is high, the node stays awake for good and the block issues nothing.

The timing base is an external tick strobe, nominally 1 ms. Two parameters set how many ticks make one sleep unit (5 s) and one reply unit (0.5 s).

Top module: `wake_sequencer`

## Requirements
- R1: While rstN is low, asleep and sendReq are both low.
- R2: With low-power mode selected, a sleep lasts sleepLen units of LONG_TICKS ticks each, counted from the cycle after entry; a value of zero acts as one. On expiry the block makes a send request with code 0xC2. With tick high every cycle, asleep stays high for sleepLen*LONG_TICKS+1 cycles.
- R3: Bit i of pinMask enables pinIn[i]. A selected pin that differs from the value captured on entry to sleep, in either direction, wakes the node with code 0xC1. sendReq appears in the third cycle after the pin changes, because of a two-flop synchronizer.
- R4: A change on a pin whose mask bit is 0 leaves the node asleep and makes no request.
- R5: After a request, the block waits replyTimeout units of SHORT_TICKS ticks; zero acts as one. If no reply arrives, it repeats the request with the same code, replyTimeout*SHORT_TICKS+2 cycles after the first one.
- R6: If the second wait also ends with no reply, the node sleeps again replyTimeout*SHORT_TICKS+2 cycles after the second request. There are never more than two requests per wake.
- R7: A replyRx pulse during the wait stops the retries. The node then stays awake for replyTimeout*SHORT_TICKS+1 cycles, counted from the cycle after the pulse, and sleeps with no further request.
- R8: A sleepNow pulse during the request, wait or post-reply phase makes asleep high in the next cycle.
- R9: If a pin wake and a timer expiry occur in the same cycle, the request carries 0xC1.
- R10: If lowPowerSelN is high while reset is held, asleep and sendReq stay low after reset, whatever the pins do. Later changes of lowPowerSelN have no effect.
- R11: sendReq is a single-cycle pulse, and sendCmd is 0 whenever sendReq is low.
- R12: The sleep timer restarts on every entry to sleep, using the sleepLen value present at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tick | input | 1 | Time-base strobe, one cycle per tick |
| lowPowerSelN | input | 1 | Low selects sleep sequencing; sampled during reset |
| pinIn | input | 8 | Monitored pins, asynchronous |
| pinMask | input | 8 | Per-pin wake enable |
| sleepLen | input | 16 | Sleep length in long units |
| replyTimeout | input | 8 | Reply window in short units |
| replyRx | input | 1 | Reply-received strobe |
| sleepNow | input | 1 | Immediate-sleep strobe |
| asleep | output | 1 | High while sleeping |
| sendReq | output | 1 | One-cycle check-in request |
| sendCmd | output | 8 | Check-in command code, valid with sendReq |

## Verification
The bench builds the block with LONG_TICKS=6 and SHORT_TICKS=3 and drives tick high every cycle. With those values a full sleep, two reply windows and a post-reply window each take only tens of cycles, so exact cycle counts can be checked for every phase. The same scaling lets a pin change be placed on the very cycle that a one-unit sleep expires. The code-priority case and the minimum sleep length are therefore checked directly, not approximately.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam logic [7:0] CMD_PIN_WAKE   = 8'hC1;
  localparam logic [7:0] CMD_TIMER_WAKE = 8'hC2;

  typedef struct packed {
    logic takeSnap;   // capture synchronized pins as the sleep reference
    logic loadLong;   // start timer with sleep length in long units
    logic loadShort;  // start timer with reply window in short units
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_INIT, ST_ON, ST_SLEEP, ST_SEND, ST_WAIT, ST_HOLD
  } wakeState_t;
endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int LEN_W       = 16,
  parameter int TMO_W       = 8,
  parameter int LONG_TICKS  = 5000,
  parameter int SHORT_TICKS = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [PIN_W-1:0] pinIn,
  input  logic [PIN_W-1:0] pinMask,
  input  logic [LEN_W-1:0] sleepLen,
  input  logic [TMO_W-1:0] replyTimeout,
  input  dpStrobe_t        strobe,
  output logic             pinChange,
  output logic             timerDone
);
  localparam int PRE_MAX = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int PRE_W   = $clog2(PRE_MAX + 1);
  localparam int CNT_W   = (LEN_W > TMO_W) ? LEN_W : TMO_W;

  logic [PIN_W-1:0] syncA, syncB, snap;
  logic [PRE_W-1:0] preCnt, preLim;
  logic [CNT_W-1:0] unitCnt;
  logic             running;

  // two-flop synchronizer and sleep-entry reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      snap  <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (strobe.takeSnap) snap <= syncB;
    end
  end

  assign pinChange = |((syncB ^ snap) & pinMask);

  // one shared prescaled down-counter serves both sleep and reply windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      preLim    <= '0;
      unitCnt   <= '0;
      running   <= 1'b0;
      timerDone <= 1'b0;
    end else if (strobe.loadLong) begin
      preCnt    <= '0;
      preLim    <= PRE_W'(LONG_TICKS - 1);
      unitCnt   <= (sleepLen == '0) ? CNT_W'(1) : CNT_W'(sleepLen);
      running   <= 1'b1;
      timerDone <= 1'b0;
    end else if (strobe.loadShort) begin
      preCnt    <= '0;
      preLim    <= PRE_W'(SHORT_TICKS - 1);
      unitCnt   <= (replyTimeout == '0) ? CNT_W'(1) : CNT_W'(replyTimeout);
      running   <= 1'b1;
      timerDone <= 1'b0;
    end else if (running && tick) begin
      if (preCnt == preLim) begin
        preCnt <= '0;
        if (unitCnt == CNT_W'(1)) begin
          running   <= 1'b0;
          timerDone <= 1'b1;
        end else begin
          unitCnt <= unitCnt - CNT_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R2
  timer_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerDone) |-> $past(tick));

  // R12
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLong || strobe.loadShort) |=> !timerDone);
endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPowerSelN,
  input  logic       pinChange,
  input  logic       timerDone,
  input  logic       replyRx,
  input  logic       sleepNow,
  output dpStrobe_t  strobe,
  output logic       asleep,
  output logic       sendReq,
  output logic [7:0] sendCmd
);
  wakeState_t state, nxtState;
  logic [7:0] codeReg, nxtCode;
  logic       secondTry, nxtSecond;
  logic       lpEn;

  // mode pin is only looked at while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) lpEn <= ~lowPowerSelN;
  end

  always_comb begin
    nxtState  = state;
    nxtCode   = codeReg;
    nxtSecond = secondTry;
    strobe    = '0;
    unique case (state)
      ST_INIT: begin
        if (lpEn) begin
          nxtState        = ST_SLEEP;
          strobe.takeSnap = 1'b1;
          strobe.loadLong = 1'b1;
        end else begin
          nxtState = ST_ON;
        end
      end
      ST_ON: nxtState = ST_ON;
      ST_SLEEP: begin
        nxtSecond = 1'b0;
        if (pinChange) begin
          nxtState = ST_SEND;
          nxtCode  = CMD_PIN_WAKE;
        end else if (timerDone) begin
          nxtState = ST_SEND;
          nxtCode  = CMD_TIMER_WAKE;
        end
      end
      ST_SEND: begin
        if (sleepNow) begin
          nxtState        = ST_SLEEP;
          strobe.takeSnap = 1'b1;
          strobe.loadLong = 1'b1;
        end else begin
          nxtState         = ST_WAIT;
          strobe.loadShort = 1'b1;
        end
      end
      ST_WAIT: begin
        if (sleepNow || (timerDone && secondTry)) begin
          nxtState        = ST_SLEEP;
          strobe.takeSnap = 1'b1;
          strobe.loadLong = 1'b1;
        end else if (replyRx) begin
          nxtState         = ST_HOLD;
          strobe.loadShort = 1'b1;
        end else if (timerDone) begin
          nxtState  = ST_SEND;
          nxtSecond = 1'b1;
        end
      end
      ST_HOLD: begin
        if (sleepNow || timerDone) begin
          nxtState        = ST_SLEEP;
          strobe.takeSnap = 1'b1;
          strobe.loadLong = 1'b1;
        end
      end
      default: nxtState = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_INIT;
      codeReg   <= '0;
      secondTry <= 1'b0;
    end else begin
      state     <= nxtState;
      codeReg   <= nxtCode;
      secondTry <= nxtSecond;
    end
  end

  assign asleep  = (state == ST_SLEEP);
  assign sendReq = (state == ST_SEND);
  assign sendCmd = sendReq ? codeReg : 8'h00;

  // R8
  sleep_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepNow && (state == ST_SEND || state == ST_WAIT || state == ST_HOLD)) |=> asleep);

  // R10
  always_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lpEn && state != ST_INIT) |-> (!asleep && !sendReq));

  // R11
  send_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |=> !sendReq);

  // R3
  pin_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && pinChange) |=> (sendReq && sendCmd == CMD_PIN_WAKE));
endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int LEN_W       = 16,
  parameter int TMO_W       = 8,
  parameter int LONG_TICKS  = 5000,
  parameter int SHORT_TICKS = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lowPowerSelN,
  input  logic [PIN_W-1:0] pinIn,
  input  logic [PIN_W-1:0] pinMask,
  input  logic [LEN_W-1:0] sleepLen,
  input  logic [TMO_W-1:0] replyTimeout,
  input  logic             replyRx,
  input  logic             sleepNow,
  output logic             asleep,
  output logic             sendReq,
  output logic [7:0]       sendCmd
);
  dpStrobe_t strobe;
  logic      pinChange, timerDone;

  wake_datapath #(
    .PIN_W(PIN_W), .LEN_W(LEN_W), .TMO_W(TMO_W),
    .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tick(tick), .pinIn(pinIn), .pinMask(pinMask),
    .sleepLen(sleepLen), .replyTimeout(replyTimeout), .strobe(strobe),
    .pinChange(pinChange), .timerDone(timerDone)
  );

  wake_control i_control (
    .clk(clk), .rstN(rstN), .lowPowerSelN(lowPowerSelN), .pinChange(pinChange),
    .timerDone(timerDone), .replyRx(replyRx), .sleepNow(sleepNow),
    .strobe(strobe), .asleep(asleep), .sendReq(sendReq), .sendCmd(sendCmd)
  );
endmodule

// File: tb/test_wake_sequencer.sv
module test_wake_sequencer;
  localparam int LT = 6;
  localparam int ST = 3;

  logic        clk = 1'b0, rstN = 1'b0, tick = 1'b1, lowPowerSelN = 1'b0;
  logic        replyRx = 1'b0, sleepNow = 1'b0;
  logic [7:0]  pinIn = '0, pinMask = '0, replyTimeout = 8'd2;
  logic [15:0] sleepLen = 16'd3;
  logic        asleep, sendReq;
  logic [7:0]  sendCmd;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  wake_sequencer #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) i_wake_sequencer (
    .clk(clk), .rstN(rstN), .tick(tick), .lowPowerSelN(lowPowerSelN),
    .pinIn(pinIn), .pinMask(pinMask), .sleepLen(sleepLen),
    .replyTimeout(replyTimeout), .replyRx(replyRx), .sleepNow(sleepNow),
    .asleep(asleep), .sendReq(sendReq), .sendCmd(sendCmd)
  );

  function automatic int sleepSpan(int len);  return (len == 0 ? 1 : len) * LT + 1; endfunction
  function automatic int waitGap(int t);      return (t == 0 ? 1 : t) * ST + 2;     endfunction
  function automatic int holdSpan(int t);     return (t == 0 ? 1 : t) * ST + 1;     endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!sendReq && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int n, extra, t, b, ub;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    check(!asleep && !sendReq, "R1 reset outputs", {asleep, sendReq}, 0);
    rstN = 1'b1;

    // R2 timer wake
    n = 0;
    while (!asleep && n < 100) begin @(negedge clk); n++; end
    sleepLen = 16'd50;
    n = 0;
    while (asleep && n < 2000) begin n++; @(negedge clk); end
    check(n == sleepSpan(3), "R2 sleep length", n, sleepSpan(3));
    check(sendReq && sendCmd == 8'hC2, "R2 timer code", sendCmd, 8'hC2);
    @(negedge clk);
    check(!sendReq && sendCmd == 8'h00, "R11 pulse and idle code", {sendReq, sendCmd}, 0);
    n = 1;
    while (!sendReq && n < 1000) begin @(negedge clk); n++; end
    check(n == waitGap(2), "R5 retry gap", n, waitGap(2));
    check(sendCmd == 8'hC2, "R5 retry code", sendCmd, 8'hC2);
    n = 0; extra = 0;
    while (!asleep && n < 1000) begin @(negedge clk); n++; if (sendReq) extra++; end
    check(n == waitGap(2) && extra == 0, "R6 give up", n, waitGap(2));

    // R3 R4 R7 R8 random pin patterns
    for (int i = 0; i < 9; i++) begin
      pinMask = 8'($urandom_range(1, 254));
      do b = $urandom_range(0, 7); while (!pinMask[b]);
      do ub = $urandom_range(0, 7); while (pinMask[ub]);
      pinIn[ub] = ~pinIn[ub];
      extra = 0;
      repeat (6) begin @(negedge clk); if (sendReq || !asleep) extra++; end
      check(extra == 0, "R4 unmasked pin ignored", extra, 0);
      t = $urandom_range(2, 4);
      replyTimeout = 8'(t);
      pinIn[b] = ~pinIn[b];
      waitReq(n);
      check(n == 3 && sendCmd == 8'hC1, "R3 pin wake", n * 256 + sendCmd, 3 * 256 + 8'hC1);
      @(negedge clk);
      if (i % 3 == 0) begin
        replyRx = 1'b1; @(negedge clk); replyRx = 1'b0;
        n = 0; extra = 0;
        while (!asleep && n < 500) begin n++; if (sendReq) extra++; @(negedge clk); end
        check(n == holdSpan(t) && extra == 0, "R7 hold after reply", n, holdSpan(t));
      end else if (i % 3 == 1) begin
        sleepNow = 1'b1; @(negedge clk); sleepNow = 1'b0;
        check(asleep, "R8 sleep now in wait", asleep, 1);
      end else begin
        replyRx = 1'b1; @(negedge clk); replyRx = 1'b0;
        @(negedge clk);
        sleepNow = 1'b1; @(negedge clk); sleepNow = 1'b0;
        check(asleep, "R8 sleep now in hold", asleep, 1);
      end
    end

    // R12 timer restarts with fresh length
    sleepLen = 16'd1;
    pinMask  = 8'hFF;
    pinIn[0] = ~pinIn[0];
    waitReq(n);
    @(negedge clk);
    sleepNow = 1'b1; @(negedge clk); sleepNow = 1'b0;
    n = 0;
    while (asleep && n < 2000) begin n++; @(negedge clk); end
    check(n == sleepSpan(1), "R12 restart length", n, sleepSpan(1));
    check(sendReq && sendCmd == 8'hC2, "R12 timer code", sendCmd, 8'hC2);
    sleepNow = 1'b1; @(negedge clk); sleepNow = 1'b0;
    check(asleep, "R8 sleep now in send", asleep, 1);

    // R9 simultaneous sources
    repeat (LT - 2) @(negedge clk);
    pinIn[1] = ~pinIn[1];
    waitReq(n);
    check(n == 3 && sendCmd == 8'hC1, "R9 pin priority", n * 256 + sendCmd, 3 * 256 + 8'hC1);
    sleepNow = 1'b1; @(negedge clk); sleepNow = 1'b0;

    // R10 permanently awake
    rstN = 1'b0; lowPowerSelN = 1'b1;
    repeat (3) @(negedge clk);
    check(!asleep && !sendReq, "R1 reset outputs again", {asleep, sendReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    lowPowerSelN = 1'b0;
    extra = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (asleep || sendReq) extra++;
      if (k % 10 == 0) pinIn = ~pinIn;
    end
    check(extra == 0, "R10 always awake", extra, 0);
    finishRun();
  end
endmodule